// File: doc/BRIEF.md
# Multi-channel frame transfer abort controller

This block is the control path of a small multi-channel transfer engine. Each channel holds a busy bit, an enable bit and a remaining-element counter. A trigger request on an idle, enabled channel starts a frame of a preset number of elements. A fixed-priority arbiter issues the elements one at a time as start/done handshakes with a data mover outside this block. Only one element is outstanding at any time.

The block watches for four kinds of fault: lost requests, parity errors, bus errors and protection faults. It also takes software writes to each channel's busy bit and to a global abort bit. From these it decides whether a frame stops, and at which element it stops. Each fault type stops the frame at a different point. A protection fault stops the frame before the faulting element is issued. A parity error stops it once the current element completes. A lost request or a bus error lets one further element go out, and a bus error also captures the counter value of that extra element. Per-channel options can suppress the abort for lost requests and for parity errors. Lost requests are also recorded in a flag register whose bits are cleared by writing 1, and this register can raise an interrupt.

Top module: `frame_abort_ctrl`

## Requirements
- R1: After reset, all busy bits, enable bits, flags, counters and the capture register are 0 and no element is issued. A request on an idle, enabled channel while the global enable is 1 sets busy and loads the counter with the frame length on the next clock. The elements are then issued with the remaining count going from the length down to 1. Busy clears when the last element completes, and enable stays 1.
- R2: Among channels with elements left, the lowest channel index is served first. No element is issued while an earlier one has not completed.
- R3: A request on a channel whose enable is 0, or while the global enable is 0, is ignored. Clearing the global enable during a frame lets that frame run to its end.
- R4: A parity error reported with an element's completion aborts the frame only when parity checking is on and the channel's continue-on-parity option is 0. Otherwise the frame carries on.
- R5: A bus error reported with an element's completion lets exactly one further element of that channel go out. Its remaining count is copied to err_cnt_o when it is issued, and the channel aborts when it completes. A bus error on the last element aborts at once.
- R6: When protection checking is on and the channel chosen for issue has its protection fault input set, no element is issued and that channel aborts on the next clock.
- R7: A request on a busy channel sets that channel's request-lost flag. If the channel's continue-on-lost option is 0, the element in progress (including one issued in the same cycle) completes, exactly one more is issued, and then the channel aborts. If the option is 1, the frame completes and the channel stays enabled.
- R8: Writing 1 to a flag bit clears it, and a set in the same cycle wins over the clear. rl_irq_o is 1 when the interrupt enable is 1 and any flag is set.
- R9: Writing 1 to the busy bit of a busy channel aborts it, and no further element of that channel is issued. Writing 1 to the busy bit of an idle channel changes nothing.
- R10: Writing 1 to the global abort bit aborts every channel and clears every enable bit.
- R11: An abort on a channel clears its busy bit, enable bit and counter, and stops its element issue. The other channels keep their state and continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| glb_en_i | input | 1 | Global enable for new frames |
| glb_rst_wr_i | input | 1 | Write 1 to abort all channels |
| par_chk_en_i | input | 1 | Parity checking on |
| prot_chk_en_i | input | 1 | Protection checking on |
| rl_irq_en_i | input | 1 | Request-lost interrupt enable |
| frame_len_i | input | CNT_W | Element count loaded at frame start (at least 1) |
| ch_en_set_i | input | NCH | Write 1 to set a channel enable |
| cont_rl_i | input | NCH | Per-channel continue-on-lost option |
| cont_pe_i | input | NCH | Per-channel continue-on-parity option |
| req_i | input | NCH | Trigger request pulses |
| busy_wr_i | input | NCH | Write 1 to a busy bit |
| rl_clr_i | input | NCH | Write 1 to clear request-lost flags |
| prot_fault_i | input | NCH | Next element of the channel would violate protection |
| xfer_done_i | input | 1 | Outstanding element completed |
| bus_err_i | input | 1 | Bus error on the completed element |
| par_err_i | input | 1 | Parity error on the completed element |
| xfer_start_o | output | 1 | Element issue strobe |
| xfer_ch_o | output | IDX_W | Channel of the issued element |
| xfer_cnt_o | output | CNT_W | Remaining count of the issued element |
| busy_o | output | NCH | Busy bits |
| ch_en_o | output | NCH | Channel enable bits |
| elem_cnt_o | output | NCH*CNT_W | Element counters, channel 0 in the low bits |
| rl_flag_o | output | NCH | Request-lost flags |
| rl_irq_o | output | 1 | Request-lost interrupt |
| err_cnt_o | output | CNT_W | Counter captured after a bus error |

## Verification
The assertions assume a well-behaved data mover and register interface. xfer_done_i pulses once for each issued element and never in the cycle of the issue. The error inputs are only meaningful together with xfer_done_i, and frame_len_i is never 0 when a frame starts. The stimulus keeps to these rules: done is driven only by the bench's responder after it has seen a start, the random phase draws lengths from 1 to 5, and error pulses are raised only together with a done.

// File: rtl/fabc_pkg.sv
package fabc_pkg;
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fabc_arb.sv
module fabc_arb #(
  parameter int N = 4,
  localparam int IDX_W = fabc_pkg::idx_w(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    vld_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req_i[i]) idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/fabc_chan.sv
module fabc_chan #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             glb_en_i,
  input  logic             par_chk_en_i,
  input  logic             cont_rl_i,
  input  logic             cont_pe_i,
  input  logic             en_set_i,
  input  logic             req_i,
  input  logic             busy_wr_i,
  input  logic             glb_rst_wr_i,
  input  logic             rl_clr_i,
  input  logic             grant_i,
  input  logic             prot_abort_i,
  input  logic             done_i,
  input  logic             bus_err_i,
  input  logic             par_err_i,
  input  logic [CNT_W-1:0] frame_len_i,
  output logic             busy_o,
  output logic             en_o,
  output logic             rl_flag_o,
  output logic             elig_o,
  output logic             cap_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic busy_q, en_q, rl_q, arm_q, arm_bus_q, last_q;
  logic [CNT_W-1:0] cnt_q;
  logic cnt_zero, done_v, par_abort, done_abort, sw_abort, abort, rl_evt, start;

  always_comb begin
    cnt_zero   = (cnt_q == '0);
    done_v     = done_i && busy_q;
    par_abort  = par_err_i && par_chk_en_i && !cont_pe_i;
    // deferred stop: extra element done, or nothing left to follow the fault
    done_abort = done_v && (par_abort || last_q || ((arm_q || bus_err_i) && cnt_zero));
    sw_abort   = (busy_wr_i && busy_q) || glb_rst_wr_i;
    abort      = sw_abort || prot_abort_i || done_abort;
    rl_evt     = req_i && busy_q;
    start      = req_i && !busy_q && en_q && glb_en_i;
    elig_o     = busy_q && !cnt_zero && !last_q && !sw_abort;
    cap_o      = grant_i && arm_q && arm_bus_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; en_q <= 1'b0; rl_q <= 1'b0;
      arm_q <= 1'b0; arm_bus_q <= 1'b0; last_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      rl_q <= (rl_q & ~rl_clr_i) | rl_evt;
      if (abort) begin
        busy_q <= 1'b0; en_q <= 1'b0; cnt_q <= '0;
        arm_q <= 1'b0; arm_bus_q <= 1'b0; last_q <= 1'b0;
      end else begin
        if (en_set_i) en_q <= 1'b1;
        if (start) begin
          busy_q <= 1'b1; cnt_q <= frame_len_i;
          arm_q <= 1'b0; arm_bus_q <= 1'b0; last_q <= 1'b0;
        end
        if (grant_i) begin
          cnt_q <= cnt_q - 1'b1;
          if (arm_q) begin
            last_q <= 1'b1; arm_q <= 1'b0; arm_bus_q <= 1'b0;
          end
        end
        if (done_v) begin
          if (bus_err_i && !last_q) begin
            arm_q <= 1'b1; arm_bus_q <= 1'b1;
          end else if (cnt_zero) begin
            busy_q <= 1'b0;
          end
        end
        if (rl_evt && !cont_rl_i && !last_q && !(grant_i && arm_q)) arm_q <= 1'b1;
      end
    end
  end

  assign busy_o    = busy_q;
  assign en_o      = en_q;
  assign rl_flag_o = rl_q;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/frame_abort_ctrl.sv
module frame_abort_ctrl #(
  parameter int NCH   = 4,
  parameter int CNT_W = 8,
  localparam int IDX_W = fabc_pkg::idx_w(NCH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               glb_en_i,
  input  logic               glb_rst_wr_i,
  input  logic               par_chk_en_i,
  input  logic               prot_chk_en_i,
  input  logic               rl_irq_en_i,
  input  logic [CNT_W-1:0]   frame_len_i,
  input  logic [NCH-1:0]     ch_en_set_i,
  input  logic [NCH-1:0]     cont_rl_i,
  input  logic [NCH-1:0]     cont_pe_i,
  input  logic [NCH-1:0]     req_i,
  input  logic [NCH-1:0]     busy_wr_i,
  input  logic [NCH-1:0]     rl_clr_i,
  input  logic [NCH-1:0]     prot_fault_i,
  input  logic               xfer_done_i,
  input  logic               bus_err_i,
  input  logic               par_err_i,
  output logic               xfer_start_o,
  output logic [IDX_W-1:0]   xfer_ch_o,
  output logic [CNT_W-1:0]   xfer_cnt_o,
  output logic [NCH-1:0]     busy_o,
  output logic [NCH-1:0]     ch_en_o,
  output logic [NCH*CNT_W-1:0] elem_cnt_o,
  output logic [NCH-1:0]     rl_flag_o,
  output logic               rl_irq_o,
  output logic [CNT_W-1:0]   err_cnt_o
);
  logic             out_q;
  logic [IDX_W-1:0] cur_q;
  logic [CNT_W-1:0] err_cnt_q;
  logic [NCH-1:0]   elig, cap, grant, pabort, done_here;
  logic [CNT_W-1:0] cnt [NCH];
  logic             pick_vld, fault, issue, blk;
  logic [IDX_W-1:0] pick;

  fabc_arb #(.N(NCH)) u_arb (
    .req_i (elig),
    .vld_o (pick_vld),
    .idx_o (pick)
  );

  always_comb begin
    fault = prot_chk_en_i && prot_fault_i[pick];
    issue = pick_vld && !out_q && !fault;
    blk   = pick_vld && !out_q && fault;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign grant[g]     = issue && (pick == IDX_W'(g));
    assign pabort[g]    = blk && (pick == IDX_W'(g));
    assign done_here[g] = xfer_done_i && out_q && (cur_q == IDX_W'(g));
    assign elem_cnt_o[g*CNT_W +: CNT_W] = cnt[g];

    fabc_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .glb_en_i     (glb_en_i),
      .par_chk_en_i (par_chk_en_i),
      .cont_rl_i    (cont_rl_i[g]),
      .cont_pe_i    (cont_pe_i[g]),
      .en_set_i     (ch_en_set_i[g]),
      .req_i        (req_i[g]),
      .busy_wr_i    (busy_wr_i[g]),
      .glb_rst_wr_i (glb_rst_wr_i),
      .rl_clr_i     (rl_clr_i[g]),
      .grant_i      (grant[g]),
      .prot_abort_i (pabort[g]),
      .done_i       (done_here[g]),
      .bus_err_i    (bus_err_i),
      .par_err_i    (par_err_i),
      .frame_len_i  (frame_len_i),
      .busy_o       (busy_o[g]),
      .en_o         (ch_en_o[g]),
      .rl_flag_o    (rl_flag_o[g]),
      .elig_o       (elig[g]),
      .cap_o        (cap[g]),
      .cnt_o        (cnt[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q     <= 1'b0;
      cur_q     <= '0;
      err_cnt_q <= '0;
    end else begin
      if (issue) begin
        out_q <= 1'b1;
        cur_q <= pick;
      end else if (xfer_done_i) begin
        out_q <= 1'b0;
      end
      if (|cap) err_cnt_q <= cnt[pick];
    end
  end

  assign xfer_start_o = issue;
  assign xfer_ch_o    = pick;
  assign xfer_cnt_o   = cnt[pick];
  assign rl_irq_o     = rl_irq_en_i && (|rl_flag_o);
  assign err_cnt_o    = err_cnt_q;
endmodule

// File: rtl/fabc_chk.sv
module fabc_chk #(
  parameter int NCH   = 4,
  parameter int CNT_W = 8,
  localparam int IDX_W = fabc_pkg::idx_w(NCH)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 glb_en_i,
  input logic                 glb_rst_wr_i,
  input logic                 prot_chk_en_i,
  input logic [NCH-1:0]       ch_en_set_i,
  input logic [NCH-1:0]       req_i,
  input logic [NCH-1:0]       busy_wr_i,
  input logic [NCH-1:0]       prot_fault_i,
  input logic                 xfer_start_o,
  input logic [IDX_W-1:0]     xfer_ch_o,
  input logic [CNT_W-1:0]     xfer_cnt_o,
  input logic [NCH-1:0]       busy_o,
  input logic [NCH-1:0]       ch_en_o,
  input logic [NCH*CNT_W-1:0] elem_cnt_o,
  input logic [NCH-1:0]       rl_flag_o
);
  // R2
  single_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |=> !xfer_start_o);

  // R1
  issue_on_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |-> busy_o[xfer_ch_o] && (xfer_cnt_o != '0));

  // R6
  no_fault_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |-> !(prot_chk_en_i && prot_fault_i[xfer_ch_o]));

  // R10
  glb_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glb_rst_wr_i |=> (busy_o == '0) && (ch_en_o == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R9
    busy_wr_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o[g] && busy_wr_i[g] |=> !busy_o[g] && !ch_en_o[g] && (elem_cnt_o[g*CNT_W +: CNT_W] == '0));

    // R9
    idle_wr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o[g] && busy_wr_i[g] && !glb_rst_wr_i && !ch_en_set_i[g] |=> ch_en_o[g] == $past(ch_en_o[g]));

    // R7
    lost_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i[g] && busy_o[g] |=> rl_flag_o[g]);

    // R3
    no_start_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !glb_en_i && !busy_o[g] |=> !busy_o[g]);
  end
endmodule

bind frame_abort_ctrl fabc_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .glb_en_i      (glb_en_i),
  .glb_rst_wr_i  (glb_rst_wr_i),
  .prot_chk_en_i (prot_chk_en_i),
  .ch_en_set_i   (ch_en_set_i),
  .req_i         (req_i),
  .busy_wr_i     (busy_wr_i),
  .prot_fault_i  (prot_fault_i),
  .xfer_start_o  (xfer_start_o),
  .xfer_ch_o     (xfer_ch_o),
  .xfer_cnt_o    (xfer_cnt_o),
  .busy_o        (busy_o),
  .ch_en_o       (ch_en_o),
  .elem_cnt_o    (elem_cnt_o),
  .rl_flag_o     (rl_flag_o)
);

// File: tb/frame_abort_ctrl_test.sv
`timescale 1ns/1ps
module frame_abort_ctrl_test;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic glb_en = 0, glb_rst_wr = 0, par_chk_en = 0, prot_chk_en = 0, rl_irq_en = 0;
  logic [7:0] frame_len = 8'd1;
  logic [3:0] en_set = 0, cont_rl = 0, cont_pe = 0, req = 0, busy_wr = 0, rl_clr = 0, prot_fault = 0;
  logic done = 0, bus_err = 0, par_err = 0;
  logic xfer_start, rl_irq;
  logic [1:0] xfer_ch;
  logic [7:0] xfer_cnt, err_cnt;
  logic [3:0] busy, ch_en, rl_flag;
  logic [31:0] elem_cnt;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  frame_abort_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .glb_en_i(glb_en), .glb_rst_wr_i(glb_rst_wr),
    .par_chk_en_i(par_chk_en), .prot_chk_en_i(prot_chk_en), .rl_irq_en_i(rl_irq_en),
    .frame_len_i(frame_len), .ch_en_set_i(en_set), .cont_rl_i(cont_rl), .cont_pe_i(cont_pe),
    .req_i(req), .busy_wr_i(busy_wr), .rl_clr_i(rl_clr), .prot_fault_i(prot_fault),
    .xfer_done_i(done), .bus_err_i(bus_err), .par_err_i(par_err),
    .xfer_start_o(xfer_start), .xfer_ch_o(xfer_ch), .xfer_cnt_o(xfer_cnt),
    .busy_o(busy), .ch_en_o(ch_en), .elem_cnt_o(elem_cnt), .rl_flag_o(rl_flag),
    .rl_irq_o(rl_irq), .err_cnt_o(err_cnt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ecnt(input int ch);
    return int'(elem_cnt[ch*8 +: 8]);
  endfunction

  task automatic clr_pulses();
    req = 0; busy_wr = 0; glb_rst_wr = 0; rl_clr = 0; en_set = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // expects an issue now, then completes it with the given error flags
  task automatic do_elem(input int ch, input int cnt, input bit b, input bit p, input string tag);
    #1;
    chk({tag, " start"}, int'(xfer_start), 1);
    chk({tag, " ch"}, int'(xfer_ch), ch);
    chk({tag, " cnt"}, int'(xfer_cnt), cnt);
    step(); clr_pulses();
    #1 chk("R2 no issue while outstanding", int'(xfer_start), 0);
    done = 1; bus_err = b; par_err = p;
    step();
    done = 0; bus_err = 0; par_err = 0;
  endtask

  task automatic no_start(input string tag);
    #1 chk(tag, int'(xfer_start), 0);
  endtask

  // random-phase model
  bit eb[4];
  int er[4];
  bit outst = 0;
  int cur = 0, lat = 0;

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) step();
    rst_ni = 1;
    step();
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset en", int'(ch_en), 0);
    chk("R1 reset flags", int'(rl_flag), 0);
    chk("R1 reset err_cnt", int'(err_cnt), 0);
    no_start("R1 reset start");

    glb_en = 1; frame_len = 3; en_set = 4'hF; step(); clr_pulses();
    chk("R1 enable", int'(ch_en), 15);

    // R1 normal frame
    req = 4'b0010; step(); clr_pulses();
    chk("R1 busy set", int'(busy), 2);
    chk("R1 counter load", ecnt(1), 3);
    do_elem(1, 3, 0, 0, "R1 e3");
    do_elem(1, 2, 0, 0, "R1 e2");
    do_elem(1, 1, 0, 0, "R1 e1");
    chk("R1 busy clear", int'(busy), 0);
    chk("R1 en kept", int'(ch_en), 15);
    no_start("R1 idle");

    // R2 priority
    frame_len = 2; req = 4'b0101; step(); clr_pulses();
    do_elem(0, 2, 0, 0, "R2 a");
    do_elem(0, 1, 0, 0, "R2 b");
    do_elem(2, 2, 0, 0, "R2 c");
    do_elem(2, 1, 0, 0, "R2 d");
    chk("R2 done", int'(busy), 0);

    // R3 global enable
    glb_en = 0; req = 4'b0001; step(); clr_pulses();
    chk("R3 ignored when off", int'(busy), 0);
    glb_en = 1; req = 4'b0001; step(); clr_pulses();
    glb_en = 0;
    do_elem(0, 2, 0, 0, "R3 a");
    do_elem(0, 1, 0, 0, "R3 b");
    chk("R3 frame finished", int'(busy), 0);
    chk("R3 en kept", int'(ch_en[0]), 1);
    glb_en = 1;

    // R4 parity
    par_chk_en = 1; frame_len = 3; req = 4'b1000; step(); clr_pulses();
    do_elem(3, 3, 0, 1, "R4 a");
    chk("R4 busy", int'(busy[3]), 0);
    chk("R4 en", int'(ch_en[3]), 0);
    chk("R11 cnt cleared", ecnt(3), 0);
    no_start("R11 stopped");
    req = 4'b1000; step(); clr_pulses();
    chk("R3 disabled ignored", int'(busy), 0);
    en_set = 4'b1000; step(); clr_pulses();
    cont_pe = 4'b1000; req = 4'b1000; step(); clr_pulses();
    do_elem(3, 3, 0, 1, "R4 cont a");
    do_elem(3, 2, 0, 0, "R4 cont b");
    do_elem(3, 1, 0, 0, "R4 cont c");
    chk("R4 cont busy", int'(busy), 0);
    chk("R4 cont en", int'(ch_en[3]), 1);
    cont_pe = 0;

    // R5 bus error
    frame_len = 4; req = 4'b0010; step(); clr_pulses();
    do_elem(1, 4, 1, 0, "R5 a");
    do_elem(1, 3, 0, 0, "R5 extra");
    chk("R5 capture", int'(err_cnt), 3);
    chk("R5 busy", int'(busy), 0);
    chk("R5 en", int'(ch_en[1]), 0);
    no_start("R5 stopped");
    en_set = 4'b0010; step(); clr_pulses();
    frame_len = 1; req = 4'b0010; step(); clr_pulses();
    do_elem(1, 1, 1, 0, "R5 last");
    chk("R5 last busy", int'(busy), 0);
    chk("R5 last en", int'(ch_en[1]), 0);
    en_set = 4'b0010; step(); clr_pulses();

    // R6 protection, R11 isolation
    prot_chk_en = 1; frame_len = 3; req = 4'b1001; step(); clr_pulses();
    do_elem(0, 3, 0, 0, "R6 a");
    prot_fault = 4'b0001;
    no_start("R6 blocked");
    step(); prot_fault = 0;
    chk("R6 busy", int'(busy), 8);
    chk("R6 en", int'(ch_en), 14);
    chk("R11 other cnt", ecnt(3), 3);
    do_elem(3, 3, 0, 0, "R11 b");
    do_elem(3, 2, 0, 0, "R11 c");
    do_elem(3, 1, 0, 0, "R11 d");
    en_set = 4'b0001; step(); clr_pulses();

    // R7 lost request, abort
    rl_irq_en = 1; frame_len = 4; req = 4'b0010; step(); clr_pulses();
    do_elem(1, 4, 0, 0, "R7 a");
    req = 4'b0010;
    do_elem(1, 3, 0, 0, "R7 b");
    chk("R7 flag", int'(rl_flag), 2);
    chk("R8 irq", int'(rl_irq), 1);
    do_elem(1, 2, 0, 0, "R7 extra");
    chk("R7 busy", int'(busy), 0);
    chk("R7 en", int'(ch_en[1]), 0);
    no_start("R7 stopped");
    en_set = 4'b0010; step(); clr_pulses();

    // R8 clear
    rl_clr = 4'b0010; step(); clr_pulses();
    chk("R8 cleared", int'(rl_flag), 0);
    chk("R8 irq low", int'(rl_irq), 0);

    // R7 continue option
    cont_rl = 4'b0100; frame_len = 3; req = 4'b0100; step(); clr_pulses();
    do_elem(2, 3, 0, 0, "R7 cont a");
    req = 4'b0100;
    do_elem(2, 2, 0, 0, "R7 cont b");
    do_elem(2, 1, 0, 0, "R7 cont c");
    chk("R7 cont busy", int'(busy), 0);
    chk("R7 cont en", int'(ch_en[2]), 1);
    chk("R7 cont flag", int'(rl_flag), 4);
    rl_clr = 4'b0100; step(); clr_pulses();
    chk("R8 clear again", int'(rl_flag), 0);

    // R8 set wins
    frame_len = 2; req = 4'b0100; step(); clr_pulses();
    req = 4'b0100; rl_clr = 4'b0100;
    do_elem(2, 2, 0, 0, "R8 a");
    chk("R8 set wins", int'(rl_flag), 4);
    do_elem(2, 1, 0, 0, "R8 b");
    rl_clr = 4'b0100; step(); clr_pulses();
    cont_rl = 0;

    // R9 busy write
    frame_len = 3; req = 4'b1000; step(); clr_pulses();
    do_elem(3, 3, 0, 0, "R9 a");
    busy_wr = 4'b1000;
    no_start("R9 no issue");
    step(); clr_pulses();
    chk("R9 busy", int'(busy), 0);
    chk("R9 en", int'(ch_en[3]), 0);
    chk("R9 cnt", ecnt(3), 0);
    busy_wr = 4'b0001; step(); clr_pulses();
    chk("R9 idle en kept", int'(ch_en[0]), 1);
    chk("R9 idle busy", int'(busy), 0);
    en_set = 4'b1000; step(); clr_pulses();

    // R10 global abort
    frame_len = 2; req = 4'b0011; step(); clr_pulses();
    do_elem(0, 2, 0, 0, "R10 a");
    glb_rst_wr = 1;
    no_start("R10 no issue");
    step(); clr_pulses();
    chk("R10 busy", int'(busy), 0);
    chk("R10 en", int'(ch_en), 0);
    no_start("R10 idle");
    en_set = 4'hF; step(); clr_pulses();

    // random phase: no faults, lost requests only flagged
    cont_rl = 4'hF; par_chk_en = 0; prot_chk_en = 0;
    for (int i = 0; i < 4; i++) begin eb[i] = 0; er[i] = 0; end
    for (int it = 0; it < 3000; it++) begin
      int ex;
      bit dn;
      logic [3:0] r;
      chk("R1 random busy", int'(busy), int'({eb[3], eb[2], eb[1], eb[0]}));
      r = (($urandom % 100) < 8) ? 4'($urandom) : 4'b0;
      req = r;
      frame_len = 8'(1 + ($urandom % 5));
      dn = outst && (lat == 0);
      done = dn;
      ex = -1;
      if (!outst)
        for (int x = 3; x >= 0; x--) if (eb[x] && er[x] != 0) ex = x;
      #1;
      chk("R2 random start", int'(xfer_start), (ex >= 0) ? 1 : 0);
      if (ex >= 0) begin
        chk("R2 random ch", int'(xfer_ch), ex);
        chk("R1 random cnt", int'(xfer_cnt), er[ex]);
      end
      for (int x = 0; x < 4; x++)
        if (r[x] && !eb[x]) begin eb[x] = 1; er[x] = int'(frame_len); end
        else if (dn && x == cur && er[x] == 0) eb[x] = 0;
      if (dn) outst = 0;
      else if (outst) lat--;
      if (ex >= 0) begin
        er[ex]--; outst = 1; cur = ex; lat = int'($urandom % 3);
      end
      step();
      done = 0; req = 0;
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule